// File: doc/BRIEF.md
# Width-Polymorphic Vector Register File

This block is an integer register file of 128 registers, each 64 bits wide, held as one flat array of bytes. A register can be read and written whole through a host port. The same bytes can also be treated as a vector of 8, 16, 32 or 64-bit lanes. A vector operand is named by a base register and continues through as many of the following registers as its length requires. The address of an element is a byte offset across the whole file, so element indices past the end of the base register run on into the next registers.

A built-in sequencer performs one predicated, element-wise add, `dst[i] = src1[i] + src2[i]`, with all three operands at one lane width. It processes one element per clock, in ascending index order, for element indices 0 through the vector length minus one. Only elements whose predicate bit is set are computed. Before it writes an element, the sequencer checks that none of the three operands would reach past the last byte of the file. If one would, the operation stops at that element and reports a fault instead of writing.

The sequencer has four states:
- `ST_IDLE` waits for a start pulse.
- `ST_RUN` handles one element per cycle.
- `ST_DONE` is a one-cycle completion state.
- `ST_FAULT` is a one-cycle completion state that also reports an error.

Its transitions are:
- *launch*: `ST_IDLE`→`ST_RUN`, on start with a non-zero length.
- *empty*: `ST_IDLE`→`ST_DONE`, on start with a length of zero.
- *advance*: `ST_RUN`→`ST_RUN`.
- *finish*: `ST_RUN`→`ST_DONE`, after the last element.
- *abort*: `ST_RUN`→`ST_FAULT`, when an enabled element is out of range.
- *retire*: `ST_DONE` or `ST_FAULT`→`ST_IDLE`.

Top module: `polywidth_regfile`

## Requirements
- R1: After reset every register reads zero, and `busy`, `done` and `err` are low.
- R2: A host write (`wr_en` high at a clock edge) stores `wr_data` into register `wr_reg`. `rd_data` shows register `rd_reg` combinationally. File byte `r*8+k` is bits `8k+7:8k` of register `r`.
- R3: `elem_width` encodes the lane width W as follows: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. Element i of an operand with base register b occupies file bytes `b*8 + i*W/8` through `b*8 + (i+1)*W/8 - 1`. Its lowest byte address holds the least significant byte, and it spills into the following registers.
- R4: Each destination element receives `(src1 + src2) mod 2^W`. No carry crosses into a neighbouring element, and bytes outside the written element are unchanged.
- R5: Element i is computed only when `pred_mask[i]` is 1. The destination bytes of a skipped element keep their value.
- R6: Elements are handled strictly in ascending index order. An element whose source overlaps the destination of a lower-indexed element sees that element's new value.
- R7: A start pulse in `ST_IDLE` with `vec_len` = N > 0 makes `busy` high from the next cycle. `done` is a one-cycle pulse that rises N+1 clock edges after the edge that sampled start, with `err` low.
- R8: With `vec_len` = 0, `done` pulses one edge after start, no register changes and `err` stays low.
- R9: Suppose enabled element k has an operand that would touch a byte at or past 1024. Then the operation stops with no write for element k. `done` and `err` pulse together k+2 edges after the start edge, and elements below k are written. An element ending exactly on byte 1023 is in range.
- R10: An element whose predicate bit is 0 never faults, even when its addresses are out of range.
- R11: Host writes presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write strobe (ignored while busy) |
| wr_reg | input | 7 | Host write register number |
| wr_data | input | 64 | Host write data |
| rd_reg | input | 7 | Host read register number |
| rd_data | output | 64 | Contents of register `rd_reg` |
| start | input | 1 | Launch a vector add (sampled in `ST_IDLE`) |
| elem_width | input | 2 | Lane width code: 0=8, 1=16, 2=32, 3=64 bits |
| vec_len | input | 7 | Vector length, 0 to 64 (larger values clamp to 64) |
| pred_mask | input | 64 | Predicate mask, bit i enables element i |
| dst_reg | input | 7 | Destination base register |
| src1_reg | input | 7 | First source base register |
| src2_reg | input | 7 | Second source base register |
| busy | output | 1 | Sequencer is in `ST_RUN` |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle fault pulse, coincident with `done` |

## Verification
Some properties are checked on every cycle:
- `done` is a single-cycle pulse that never overlaps `busy`.
- `err` only appears with `done`.
- A zero-length start completes on the next edge, and a non-zero start raises `busy`.
- No element is written in the cycle that aborts.
- The store receives no write while `busy` is high and the sequencer itself is not writing.

Other behaviour is shown only by the bench's scenarios, against a byte-level model:
- the lane layout and spill across registers;
- modular lane sums with carry isolation;
- predicate skipping;
- ordering between overlapping operands;
- the exact completion cycle;
- fault position and boundary;
- the non-faulting of masked elements.

// File: rtl/pwrf_pkg.sv
`timescale 1ns/1ps
package pwrf_pkg;

    // Lane width codes; the numeric code is log2 of the lane size in bytes.
    typedef enum logic [1:0] {
        EW_B8  = 2'd0,
        EW_B16 = 2'd1,
        EW_B32 = 2'd2,
        EW_B64 = 2'd3
    } elem_width_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE,
        ST_FAULT
    } seq_state_e;

    // Operand slots used by the address generators.
    localparam int NUM_OPS = 3;
    localparam int OP_DST  = 0;
    localparam int OP_SRC1 = 1;
    localparam int OP_SRC2 = 2;

    function automatic logic [3:0] elem_bytes(input elem_width_e w);
        return 4'd1 << w;
    endfunction

endpackage

// File: rtl/pwrf_elem_addr.sv
`timescale 1ns/1ps
// Byte address of one element of one operand, plus a range flag.
module pwrf_elem_addr #(
    parameter int RNUM_W     = 7,
    parameter int REG_BYTES  = 8,
    parameter int IDX_W      = 6,
    parameter int FILE_BYTES = 1024,
    parameter int ADDR_W     = 10,
    parameter int EXT_W      = 11
) (
    input  logic [RNUM_W-1:0]      base,
    input  logic [IDX_W-1:0]       idx,
    input  pwrf_pkg::elem_width_e  ew,
    output logic [ADDR_W-1:0]      addr,
    output logic                   oob
);
    localparam int LG_REG = $clog2(REG_BYTES);

    logic [EXT_W-1:0] first_byte;
    logic [EXT_W-1:0] end_byte;   // one past the last byte of the element

    always_comb begin
        first_byte = (EXT_W'(base) << LG_REG) + (EXT_W'(idx) << ew);
        end_byte   = first_byte + EXT_W'(pwrf_pkg::elem_bytes(ew));
        oob        = end_byte > EXT_W'(FILE_BYTES);
        addr       = first_byte[ADDR_W-1:0];
    end

endmodule

// File: rtl/pwrf_byte_store.sv
`timescale 1ns/1ps
// Flat byte array: one byte-enabled write window, several read windows.
// FILE_BYTES must equal 2**ADDR_W.
module pwrf_byte_store #(
    parameter int FILE_BYTES = 1024,
    parameter int ADDR_W     = 10,
    parameter int PORT_BYTES = 8,
    parameter int NUM_RD     = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [PORT_BYTES-1:0]     wbe,
    input  logic [PORT_BYTES*8-1:0]   wdata,
    input  logic [ADDR_W-1:0]         raddr [NUM_RD],
    output logic [PORT_BYTES*8-1:0]   rdata [NUM_RD]
);
    logic [7:0] mem [FILE_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < FILE_BYTES; a++) begin
                mem[a] <= '0;
            end
        end else if (we) begin
            for (int k = 0; k < PORT_BYTES; k++) begin
                if (wbe[k]) begin
                    mem[waddr + ADDR_W'(k)] <= wdata[8*k +: 8];
                end
            end
        end
    end

    // Read windows wrap modulo the file size; callers only use in-range windows.
    for (genvar p = 0; p < NUM_RD; p++) begin : g_port
        for (genvar k = 0; k < PORT_BYTES; k++) begin : g_byte
            assign rdata[p][8*k +: 8] = mem[raddr[p] + ADDR_W'(k)];
        end
    end

endmodule

// File: rtl/pwrf_lane_add.sv
`timescale 1ns/1ps
// Segmented adder: the byte carry chain is cut at every lane boundary.
module pwrf_lane_add #(
    parameter int LANE_BYTES = 8
) (
    input  logic [LANE_BYTES*8-1:0] a,
    input  logic [LANE_BYTES*8-1:0] b,
    input  pwrf_pkg::elem_width_e   ew,
    output logic [LANE_BYTES*8-1:0] sum
);
    logic [3:0]            eb;
    logic [LANE_BYTES-1:0] carry;

    assign eb       = pwrf_pkg::elem_bytes(ew);
    assign carry[0] = 1'b0;

    for (genvar k = 0; k < LANE_BYTES; k++) begin : g_byte
        localparam logic [3:0] KPOS = 4'(k);
        logic cin;

        // A byte whose position is a multiple of the lane size starts a lane.
        assign cin = ((KPOS & (eb - 4'd1)) == 4'd0) ? 1'b0 : carry[k];

        if (k == LANE_BYTES - 1) begin : g_top
            assign sum[8*k +: 8] = a[8*k +: 8] + b[8*k +: 8] + {7'd0, cin};
        end else begin : g_mid
            logic [8:0] part;
            assign part          = {1'b0, a[8*k +: 8]} + {1'b0, b[8*k +: 8]} + {8'd0, cin};
            assign sum[8*k +: 8] = part[7:0];
            assign carry[k+1]    = part[8];
        end
    end

endmodule

// File: rtl/pwrf_seq.sv
`timescale 1ns/1ps
// Element loop controller for the predicated vector add.
module pwrf_seq #(
    parameter int RNUM_W = 7,
    parameter int VL_W   = 7,
    parameter int IDX_W  = 6,
    parameter int MAX_VL = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  pwrf_pkg::elem_width_e   ew_in,
    input  logic [VL_W-1:0]         vl_in,
    input  logic [MAX_VL-1:0]       mask_in,
    input  logic [RNUM_W-1:0]       dst_in,
    input  logic [RNUM_W-1:0]       src1_in,
    input  logic [RNUM_W-1:0]       src2_in,
    input  logic                    any_oob,
    output pwrf_pkg::elem_width_e   ew_q,
    output logic [IDX_W-1:0]        idx_q,
    output logic [RNUM_W-1:0]       dst_q,
    output logic [RNUM_W-1:0]       src1_q,
    output logic [RNUM_W-1:0]       src2_q,
    output logic                    elem_we,
    output logic                    busy,
    output logic                    done,
    output logic                    err
);
    import pwrf_pkg::*;

    seq_state_e        state;
    seq_state_e        state_nx;
    logic [VL_W-1:0]   vl_q;
    logic [MAX_VL-1:0] mask_q;
    logic              elem_on;
    logic              last_elem;
    logic              abort_now;
    logic              launch;

    always_comb begin
        elem_on   = mask_q[idx_q];
        last_elem = (VL_W'(idx_q) + VL_W'(1)) == vl_q;
        abort_now = elem_on && any_oob;
        launch    = (state == ST_IDLE) && start;
    end

    // Next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = (vl_in == '0) ? ST_DONE : ST_RUN;     // empty / launch
                end
            end
            ST_RUN: begin
                if (abort_now) begin
                    state_nx = ST_FAULT;                             // abort
                end else if (last_elem) begin
                    state_nx = ST_DONE;                              // finish
                end
            end
            ST_DONE, ST_FAULT: state_nx = ST_IDLE;                   // retire
            default:           state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Operation context and element index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ew_q   <= EW_B8;
            vl_q   <= '0;
            mask_q <= '0;
            dst_q  <= '0;
            src1_q <= '0;
            src2_q <= '0;
            idx_q  <= '0;
        end else if (launch) begin
            ew_q   <= ew_in;
            vl_q   <= (vl_in > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vl_in;
            mask_q <= mask_in;
            dst_q  <= dst_in;
            src1_q <= src1_in;
            src2_q <= src2_in;
            idx_q  <= '0;
        end else if (state == ST_RUN && !abort_now && !last_elem) begin
            idx_q  <= idx_q + 1'b1;                                  // advance
        end
    end

    // Outputs
    always_comb begin
        busy    = (state == ST_RUN);
        done    = (state == ST_DONE) || (state == ST_FAULT);
        err     = (state == ST_FAULT);
        elem_we = (state == ST_RUN) && elem_on && !any_oob;
    end

endmodule

// File: rtl/polywidth_regfile.sv
`timescale 1ns/1ps
// Register file viewable as 8/16/32/64-bit lanes, with a predicated vector add.
// REG_BYTES must be 8 (the widest lane) and NUM_REGS*REG_BYTES a power of two.
module polywidth_regfile
    import pwrf_pkg::*;
#(
    parameter int NUM_REGS  = 128,
    parameter int REG_BYTES = 8,
    parameter int MAX_VL    = 64,
    localparam int RNUM_W     = $clog2(NUM_REGS),
    localparam int REG_W      = REG_BYTES * 8,
    localparam int VL_W       = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RNUM_W-1:0] wr_reg,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [RNUM_W-1:0] rd_reg,
    output logic [REG_W-1:0]  rd_data,
    input  logic              start,
    input  logic [1:0]        elem_width,
    input  logic [VL_W-1:0]   vec_len,
    input  logic [MAX_VL-1:0] pred_mask,
    input  logic [RNUM_W-1:0] dst_reg,
    input  logic [RNUM_W-1:0] src1_reg,
    input  logic [RNUM_W-1:0] src2_reg,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int FILE_BYTES = NUM_REGS * REG_BYTES;
    localparam int ADDR_W     = $clog2(FILE_BYTES);
    localparam int LG_REG     = $clog2(REG_BYTES);
    localparam int IDX_W      = $clog2(MAX_VL);
    localparam int EXT_W      = $clog2(FILE_BYTES + MAX_VL * REG_BYTES + 1);
    localparam int NUM_RD     = 3;
    localparam int RD_SRC1    = 0;
    localparam int RD_SRC2    = 1;
    localparam int RD_HOST    = 2;

    elem_width_e        ew_q;
    logic [IDX_W-1:0]   idx_q;
    logic [RNUM_W-1:0]  dst_q;
    logic [RNUM_W-1:0]  src1_q;
    logic [RNUM_W-1:0]  src2_q;
    logic               seq_we;
    logic               any_oob;

    logic [RNUM_W-1:0]  op_base [NUM_OPS];
    logic [ADDR_W-1:0]  op_addr [NUM_OPS];
    logic [NUM_OPS-1:0] op_oob;

    logic [ADDR_W-1:0]  rd_addr [NUM_RD];
    logic [REG_W-1:0]   rd_win  [NUM_RD];

    logic               st_we;
    logic [ADDR_W-1:0]  st_waddr;
    logic [REG_BYTES-1:0] st_wbe;
    logic [REG_W-1:0]   st_wdata;
    logic [REG_W-1:0]   lane_sum;
    logic [REG_BYTES-1:0] lane_be;

    pwrf_seq #(
        .RNUM_W (RNUM_W),
        .VL_W   (VL_W),
        .IDX_W  (IDX_W),
        .MAX_VL (MAX_VL)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .ew_in   (elem_width_e'(elem_width)),
        .vl_in   (vec_len),
        .mask_in (pred_mask),
        .dst_in  (dst_reg),
        .src1_in (src1_reg),
        .src2_in (src2_reg),
        .any_oob (any_oob),
        .ew_q    (ew_q),
        .idx_q   (idx_q),
        .dst_q   (dst_q),
        .src1_q  (src1_q),
        .src2_q  (src2_q),
        .elem_we (seq_we),
        .busy    (busy),
        .done    (done),
        .err     (err)
    );

    assign op_base[OP_DST]  = dst_q;
    assign op_base[OP_SRC1] = src1_q;
    assign op_base[OP_SRC2] = src2_q;

    for (genvar o = 0; o < NUM_OPS; o++) begin : g_op
        pwrf_elem_addr #(
            .RNUM_W     (RNUM_W),
            .REG_BYTES  (REG_BYTES),
            .IDX_W      (IDX_W),
            .FILE_BYTES (FILE_BYTES),
            .ADDR_W     (ADDR_W),
            .EXT_W      (EXT_W)
        ) u_addr (
            .base (op_base[o]),
            .idx  (idx_q),
            .ew   (ew_q),
            .addr (op_addr[o]),
            .oob  (op_oob[o])
        );
    end

    assign any_oob = |op_oob;

    assign rd_addr[RD_SRC1] = op_addr[OP_SRC1];
    assign rd_addr[RD_SRC2] = op_addr[OP_SRC2];
    assign rd_addr[RD_HOST] = {rd_reg, {LG_REG{1'b0}}};
    assign rd_data          = rd_win[RD_HOST];

    pwrf_lane_add #(
        .LANE_BYTES (REG_BYTES)
    ) u_add (
        .a   (rd_win[RD_SRC1]),
        .b   (rd_win[RD_SRC2]),
        .ew  (ew_q),
        .sum (lane_sum)
    );

    // Only the bytes of the current element are written back.
    for (genvar k = 0; k < REG_BYTES; k++) begin : g_be
        assign lane_be[k] = (4'(k) < elem_bytes(ew_q));
    end

    // The sequencer owns the write port while running; host writes are dropped.
    always_comb begin
        if (busy) begin
            st_we    = seq_we;
            st_waddr = op_addr[OP_DST];
            st_wbe   = lane_be;
            st_wdata = lane_sum;
        end else begin
            st_we    = wr_en;
            st_waddr = {wr_reg, {LG_REG{1'b0}}};
            st_wbe   = '1;
            st_wdata = wr_data;
        end
    end

    pwrf_byte_store #(
        .FILE_BYTES (FILE_BYTES),
        .ADDR_W     (ADDR_W),
        .PORT_BYTES (REG_BYTES),
        .NUM_RD     (NUM_RD)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_we),
        .waddr (st_waddr),
        .wbe   (st_wbe),
        .wdata (st_wdata),
        .raddr (rd_addr),
        .rdata (rd_win)
    );

endmodule

// File: rtl/pwrf_chk.sv
`timescale 1ns/1ps
module pwrf_chk #(
    parameter int VL_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [VL_W-1:0] vec_len,
    input logic            busy,
    input logic            done,
    input logic            err,
    input logic            seq_we,
    input logic            st_we
);
    // R7
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    busy_excl_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R7
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && vec_len != '0) |=> busy);

    // R8
    empty_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && vec_len == '0) |=> (done && !err));

    // R9
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R9
    abort_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !$past(seq_we));

    // R11
    host_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !seq_we) |-> !st_we);
endmodule

bind polywidth_regfile pwrf_chk #(.VL_W(VL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .vec_len (vec_len),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .seq_we  (seq_we),
    .st_we   (st_we)
);

// File: tb/tb_polywidth_regfile.sv
`timescale 1ns/1ps
module tb_polywidth_regfile;
    localparam int NREG = 128;
    localparam int FB   = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_reg = '0;
    logic [63:0] wr_data = '0;
    logic [6:0]  rd_reg = '0;
    logic [63:0] rd_data;
    logic        start = 1'b0;
    logic [1:0]  elem_width = '0;
    logic [6:0]  vec_len = '0;
    logic [63:0] pred_mask = '0;
    logic [6:0]  dst_reg = '0;
    logic [6:0]  src1_reg = '0;
    logic [6:0]  src2_reg = '0;
    logic        busy, done, err;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [FB];

    always #2 clk = ~clk;

    polywidth_regfile dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data),
        .rd_reg(rd_reg), .rd_data(rd_data),
        .start(start), .elem_width(elem_width), .vec_len(vec_len),
        .pred_mask(pred_mask), .dst_reg(dst_reg), .src1_reg(src1_reg),
        .src2_reg(src2_reg), .busy(busy), .done(done), .err(err)
    );

    function automatic logic [63:0] pat(input int r, input int s);
        logic [63:0] x;
        if (s < 0) return 64'hFFFF_FFFF_FFFF_FFFF;
        x = 64'h9E37_79B9_7F4A_7C15 * 64'(r + 1) + 64'hD1B5_4A32_D192_ED03 * 64'(s + 3);
        x = x ^ (x >> 29);
        return x;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic host_write(input int r, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_reg = 7'(r); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        for (int k = 0; k < 8; k++) mdl[r*8 + k] = d[8*k +: 8];
    endtask

    task automatic fill(input int s);
        for (int r = 0; r < NREG; r++) host_write(r, pat(r, s));
    endtask

    task automatic compare_all(input string req, input string what);
        int bad = 0;
        int first_r = 0;
        logic [63:0] exp_v;
        logic [63:0] first_a = '0;
        logic [63:0] first_e = '0;
        for (int r = 0; r < NREG; r++) begin
            rd_reg = 7'(r);
            #0.5;
            for (int k = 0; k < 8; k++) exp_v[8*k +: 8] = mdl[r*8 + k];
            if (rd_data !== exp_v) begin
                if (bad == 0) begin
                    first_r = r; first_a = rd_data; first_e = exp_v;
                end
                bad++;
            end
        end
        check(bad == 0, req, $sformatf("%s reg %0d (%0d regs differ)", what, first_r, bad),
              first_a, first_e);
    endtask

    task automatic run_op(input int ew, input int vl, input logic [63:0] m,
                          input int rd, input int rs1, input int rs2,
                          input bit poke, input string req, input string what);
        int wb;
        int fault_k;
        int exp_cyc;
        int cyc;
        wb = 1 << ew;
        fault_k = -1;
        // byte-level model of the predicated add
        for (int i = 0; i < vl; i++) begin
            int ad;
            int a1;
            int a2;
            logic [63:0] x;
            logic [63:0] y;
            logic [63:0] z;
            ad = rd * 8 + i * wb;
            a1 = rs1 * 8 + i * wb;
            a2 = rs2 * 8 + i * wb;
            if (m[i]) begin
                if (ad + wb > FB || a1 + wb > FB || a2 + wb > FB) begin
                    fault_k = i;
                    break;
                end
                x = '0; y = '0;
                for (int k = 0; k < wb; k++) begin
                    x[8*k +: 8] = mdl[a1 + k];
                    y[8*k +: 8] = mdl[a2 + k];
                end
                z = x + y;
                for (int k = 0; k < wb; k++) mdl[ad + k] = z[8*k +: 8];
            end
        end
        exp_cyc = (fault_k >= 0) ? fault_k + 2 : vl + 1;

        @(negedge clk);
        elem_width = 2'(ew); vec_len = 7'(vl); pred_mask = m;
        dst_reg = 7'(rd); src1_reg = 7'(rs1); src2_reg = 7'(rs2);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        check(busy == (vl > 0), req, $sformatf("%s busy after start", what),
              64'(busy), 64'(vl > 0));
        if (poke) begin
            wr_en = 1'b1; wr_reg = 7'd100; wr_data = 64'hDEAD_BEEF_0BAD_F00D;
        end
        while (!done && cyc < 300) begin
            @(negedge clk);
            wr_en = 1'b0;
            cyc++;
        end
        wr_en = 1'b0;
        check(cyc == exp_cyc, req, $sformatf("%s cycles to done", what),
              64'(cyc), 64'(exp_cyc));
        check(err == (fault_k >= 0), req, $sformatf("%s err at done (fault elem %0d)", what, fault_k),
              64'(err), 64'(fault_k >= 0));
    endtask

    initial begin
        int vls [7];
        logic [63:0] masks [3];
        int s;
        vls = '{0, 1, 7, 8, 9, 33, 64};
        masks = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_5555_5555_5555, 64'hF0C3_9A1E_7B24_6D58};
        for (int a = 0; a < FB; a++) mdl[a] = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1", "busy after reset", 64'(busy), 64'd0);
        check(done == 1'b0, "R1", "done after reset", 64'(done), 64'd0);
        check(err == 1'b0, "R1", "err after reset", 64'(err), 64'd0);
        compare_all("R1", "file after reset");

        // R2: host write and read back
        fill(1);
        compare_all("R2", "host fill");

        // R3 R4 R5 R6 R7 R8: sweep of widths, lengths and masks
        s = 10;
        for (int ew = 0; ew < 4; ew++) begin
            for (int vi = 0; vi < 7; vi++) begin
                for (int mi = 0; mi < 3; mi++) begin
                    string rq;
                    rq = (vls[vi] == 0) ? "R8" : "R7";
                    fill((mi == 1 && vi == 3) ? -1 : s);
                    run_op(ew, vls[vi], masks[mi], (s * 7) % 60, (s * 5) % 40, (s * 11) % 50,
                           1'b0, rq, $sformatf("sweep ew%0d vl%0d m%0d", ew, vls[vi], mi));
                    compare_all((vls[vi] == 0) ? "R8" : "R3/R4/R5/R6",
                                $sformatf("sweep ew%0d vl%0d m%0d", ew, vls[vi], mi));
                    s++;
                end
            end
        end

        // R9: destination runs past the end, 64-bit lanes, faults at element 3
        fill(200);
        run_op(3, 8, 64'hFFFF_FFFF_FFFF_FFFF, 125, 0, 10, 1'b0, "R9", "dst overrun");
        compare_all("R9", "dst overrun partial writes");

        // R9: second source runs past the end, 32-bit lanes, faults at element 2
        fill(201);
        run_op(2, 10, 64'hFFFF_FFFF_FFFF_FFFF, 20, 30, 127, 1'b0, "R9", "src2 overrun");
        compare_all("R9", "src2 overrun partial writes");

        // R9: last element ends exactly on byte 1023
        fill(203);
        run_op(0, 64, 64'hFFFF_FFFF_FFFF_FFFF, 120, 0, 60, 1'b0, "R9", "exact end boundary");
        compare_all("R9", "exact end boundary");

        // R10: out-of-range elements masked off never fault
        fill(202);
        run_op(3, 8, 64'h0000_0000_0000_0007, 125, 0, 10, 1'b0, "R10", "masked overrun");
        compare_all("R10", "masked overrun");

        // R5: all predicate bits clear
        fill(204);
        run_op(1, 64, 64'h0, 0, 10, 20, 1'b0, "R5", "empty mask");
        compare_all("R5", "empty mask leaves file");

        // R11: host write while busy is dropped
        fill(205);
        run_op(3, 16, 64'hFFFF_FFFF_FFFF_FFFF, 0, 20, 40, 1'b1, "R11", "host write during run");
        compare_all("R11", "host write during run");

        // R8: zero length at the very end of the file
        fill(206);
        run_op(3, 0, 64'hFFFF_FFFF_FFFF_FFFF, 127, 127, 127, 1'b0, "R8", "zero length at end");
        compare_all("R8", "zero length at end");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R7 watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule